// File: doc/BRIEF.md
# DAC Code Latch with Deferred Update Triggers

This block is the register front end of a 12-bit digital-to-analog converter. Software writes the two data bytes over a byte-wide write port, low byte first and then high byte. The bytes go into holding registers. From them the block builds a 12-bit code, packed either from the bottom of the two bytes (right-justified) or from the top (left-justified).

The code moves into the output register only when the update event chosen in the control register occurs. That event is either the high-byte write itself or an overflow pulse from one of three timers. Deferring the update to a timer lets software stage a new sample at any time while the output still changes at a fixed rate.

A disable bit freezes the output and blocks all update events. The holding registers keep accepting writes while the block is disabled.

Top module: `dac_code_latch`

## Requirements
- R1: After reset the output code is 0x000 and `dacEnabled` is 0. The control state is also cleared, which means disabled, update on high-byte write, and right-justified.
- R2: Address 0 is the control register, address 1 the low byte and address 2 the high byte. A write to address 3 changes nothing. In the control byte, bit 7 is enable, bits 4..3 are the update mode and bits 2..0 are the data format. `dacEnabled` shows bit 7 from the cycle after the control write.
- R3: In update mode 00, a high-byte write while enabled changes `dacCode` in the cycle after that write. Writes to the low byte and to the control register leave `dacCode` unchanged.
- R4: Mode 01 transfers on a pulse of `tmr3Ovf`, mode 10 on `tmr4Ovf` and mode 11 on `tmr2Ovf`. The code appears in the cycle after the pulse. Pulses from the timers that are not selected have no effect.
- R5: In the timer modes (01, 10, 11), a high-byte write does not change `dacCode`.
- R6: Format 000 (right-justified) gives the code {high[3:0], low[7:0]}. Bits 7..4 of the high byte are ignored.
- R7: Format 111 (left-justified) gives the code {high[7:0], low[7:4]}. Bits 3..0 of the low byte are ignored.
- R8: Format codes other than 000 and 111 are handled exactly like 000.
- R9: While the block is disabled, `dacCode` holds its value. High-byte writes and timer pulses do not change it, but the byte writes still reach the holding registers.
- R10: When a byte write and the selected timer pulse fall in the same cycle, the transferred code already contains the byte written in that cycle.
- R11: When a control write and a timer pulse fall in the same cycle, the pulse is judged with the enable, mode and format that were in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 control, 1 low, 2 high) |
| wrData | input | 8 | Write data byte |
| tmr2Ovf | input | 1 | Timer 2 overflow pulse |
| tmr3Ovf | input | 1 | Timer 3 overflow pulse |
| tmr4Ovf | input | 1 | Timer 4 overflow pulse |
| dacCode | output | 12 | Output code for the converter |
| dacEnabled | output | 1 | Enable state from the control register |

## Verification
A register write and a timer overflow can land on the same clock edge, and the bench drives both cases on purpose. In the first, a high byte is written in the very cycle the selected overflow fires. The bench expects the output code to contain that new byte. In the second, a control write that disables the block coincides with an overflow. The bench expects the transfer to still happen under the old settings, and a later overflow to be ignored.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_LOW  = 1;
  localparam int ADDR_HIGH = 2;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_LSB = 3;
  localparam int CTRL_FMT_LSB  = 0;
  localparam logic [2:0] FMT_LEFT = 3'b111;

  typedef enum logic [1:0] {
    UPD_ON_HIGH = 2'b00,
    UPD_ON_TMR3 = 2'b01,
    UPD_ON_TMR4 = 2'b10,
    UPD_ON_TMR2 = 2'b11
  } updMode_e;

  typedef struct packed {
    logic ldLow;
    logic ldHigh;
    logic xfer;
    logic leftJust;
  } dacStrobe_t;

endpackage

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
  import dac_latch_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              tmr2Ovf,
  input  logic              tmr3Ovf,
  input  logic              tmr4Ovf,
  output dacStrobe_t        strb,
  output logic              enOut,
  output updMode_e          modeOut
);

  logic     enQ;
  updMode_e modeQ;
  logic [2:0] fmtQ;

  logic selCtrl, selLow, selHigh;
  logic updEvent;

  assign selCtrl = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign selLow  = wrEn && (wrAddr == ADDR_W'(ADDR_LOW));
  assign selHigh = wrEn && (wrAddr == ADDR_W'(ADDR_HIGH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      modeQ <= UPD_ON_HIGH;
      fmtQ  <= 3'b000;
    end else if (selCtrl) begin
      enQ   <= wrData[CTRL_EN_BIT];
      modeQ <= updMode_e'(wrData[CTRL_MODE_LSB +: 2]);
      fmtQ  <= wrData[CTRL_FMT_LSB +: 3];
    end
  end

  always_comb begin
    unique case (modeQ)
      UPD_ON_HIGH: updEvent = selHigh;
      UPD_ON_TMR3: updEvent = tmr3Ovf;
      UPD_ON_TMR4: updEvent = tmr4Ovf;
      UPD_ON_TMR2: updEvent = tmr2Ovf;
      default:     updEvent = 1'b0;
    endcase
  end

  assign strb.ldLow    = selLow;
  assign strb.ldHigh   = selHigh;
  assign strb.xfer     = enQ && updEvent;
  assign strb.leftJust = (fmtQ == FMT_LEFT);

  assign enOut   = enQ;
  assign modeOut = modeQ;

  // R2: the enable flag follows bit 7 of the last control write
  a_r2_enable_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    selCtrl |=> (enOut == $past(wrData[CTRL_EN_BIT])));

endmodule

// File: rtl/dac_latch_datapath.sv
module dac_latch_datapath
  import dac_latch_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CODE_W-1:0] codeOut
);

  localparam int EXTRA_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] lowQ, highQ, lowNext, highNext;
  logic [CODE_W-1:0] codeQ, assembled;

  assign lowNext  = strb.ldLow  ? wrData : lowQ;
  assign highNext = strb.ldHigh ? wrData : highQ;

  generate
    if (EXTRA_W > 0 && EXTRA_W <= BYTE_W) begin : g_pack
      always_comb begin
        if (strb.leftJust)
          assembled = {highNext, lowNext[BYTE_W-1 -: EXTRA_W]};
        else
          assembled = {highNext[EXTRA_W-1:0], lowNext};
      end
    end else begin : g_bad_width
      initial $error("dac_latch_datapath: CODE_W must lie in (BYTE_W, 2*BYTE_W]");
      assign assembled = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ  <= '0;
      highQ <= '0;
      codeQ <= '0;
    end else begin
      lowQ  <= lowNext;
      highQ <= highNext;
      if (strb.xfer) codeQ <= assembled;
    end
  end

  assign codeOut = codeQ;

endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
  import dac_latch_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              tmr2Ovf,
  input  logic              tmr3Ovf,
  input  logic              tmr4Ovf,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacEnabled
);

  localparam int EXTRA_W = CODE_W - BYTE_W;

  dacStrobe_t strb;
  updMode_e   curMode;

  dac_latch_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf), .tmr4Ovf(tmr4Ovf),
    .strb(strb), .enOut(dacEnabled), .modeOut(curMode)
  );

  dac_latch_datapath #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .codeOut(dacCode)
  );

  logic highWr;
  assign highWr = wrEn && (wrAddr == ADDR_W'(ADDR_HIGH));

  // R9: disabled output never moves
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dacEnabled |=> $stable(dacCode));

  // R3: in write-triggered mode only a high write moves the output
  a_r3_only_high_updates: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == UPD_ON_HIGH && !highWr) |=> $stable(dacCode));

  // R4: in a timer mode nothing moves the output without an overflow pulse
  a_r4_no_pulse_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != UPD_ON_HIGH && !(tmr2Ovf || tmr3Ovf || tmr4Ovf)) |=> $stable(dacCode));

  // R6: right-justified high write places the high byte's low bits on top
  a_r6_right_top_bits: assert property (@(posedge clk) disable iff (!rstN)
    (dacEnabled && curMode == UPD_ON_HIGH && highWr && !strb.leftJust)
      |=> (dacCode[CODE_W-1 -: EXTRA_W] == $past(wrData[EXTRA_W-1:0])));

endmodule

// File: tb/tb_dac_code_latch.sv
module tb_dac_code_latch;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        tmr2Ovf = 1'b0, tmr3Ovf = 1'b0, tmr4Ovf = 1'b0;
  logic [11:0] dacCode;
  logic        dacEnabled;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_code_latch dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf), .tmr4Ovf(tmr4Ovf),
    .dacCode(dacCode), .dacEnabled(dacEnabled)
  );

  // {ctrl, low, high, pulse(0 none,1 t2,2 t3,3 t4), expected code}
  localparam logic [37:0] VEC [NVEC] = '{
    {8'h80, 8'h34, 8'h12, 2'd0, 12'h234},  // R3 R6
    {8'h87, 8'hAB, 8'hCD, 2'd0, 12'hCDA},  // R7
    {8'h88, 8'h56, 8'hF7, 2'd2, 12'h756},  // R4 mode01 tmr3, R6
    {8'h8F, 8'h9E, 8'h3C, 2'd1, 12'h756},  // R4 wrong timer ignored
    {8'h97, 8'h9E, 8'h3C, 2'd3, 12'h3C9},  // R4 mode10 tmr4, R7
    {8'h9B, 8'h21, 8'hA5, 2'd1, 12'h521},  // R4 mode11 tmr2, R8
    {8'h98, 8'hFF, 8'hFF, 2'd2, 12'h521},  // R4 wrong timer ignored
    {8'h18, 8'h00, 8'h00, 2'd1, 12'h521},  // R9 disabled
    {8'h05, 8'h11, 8'h22, 2'd0, 12'h521},  // R9 disabled, write mode
    {8'h85, 8'h11, 8'h22, 2'd0, 12'h211}   // R8 fmt 101 right
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic [1:0] pulse);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d;
    tmr2Ovf = (pulse == 2'd1);
    tmr3Ovf = (pulse == 2'd2);
    tmr4Ovf = (pulse == 2'd3);
    @(negedge clk);
    wrEn = 1'b0; tmr2Ovf = 1'b0; tmr3Ovf = 1'b0; tmr4Ovf = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] prevExp;
    repeat (3) @(negedge clk);
    check("R1 reset code", dacCode, 12'h000);
    check("R1 reset enable", {11'd0, dacEnabled}, 12'h000);
    rstN = 1'b1;

    prevExp = 12'h000;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c, lo, hi;
      logic [1:0] p;
      logic [11:0] e;
      {c, lo, hi, p, e} = VEC[i];
      step(1'b1, 2'd0, c, 2'd0);
      check("R2 enable bit", {11'd0, dacEnabled}, {11'd0, c[7]});
      check("R3 ctrl write no update", dacCode, prevExp);
      step(1'b1, 2'd1, lo, 2'd0);
      check("R3 low write no update", dacCode, prevExp);
      step(1'b1, 2'd2, hi, 2'd0);
      if (c[7] && c[4:3] == 2'b00)
        check("R3 high write update", dacCode, e);
      else
        check("R5 R9 high write no update", dacCode, prevExp);
      if (p != 2'd0) begin
        step(1'b0, 2'd0, 8'h00, p);
        check("R4 timer transfer", dacCode, e);
      end
      prevExp = e;
    end

    // R2: address 3 ignored (holding low byte kept)
    step(1'b1, 2'd0, 8'h80, 2'd0);
    step(1'b1, 2'd1, 8'h5A, 2'd0);
    step(1'b1, 2'd3, 8'hFF, 2'd0);
    check("R2 addr3 no effect", dacCode, 12'h211);
    step(1'b1, 2'd2, 8'h03, 2'd0);
    check("R2 addr3 holding intact", dacCode, 12'h35A);

    // R10: high write in same cycle as selected overflow
    step(1'b1, 2'd0, 8'h88, 2'd0);
    step(1'b1, 2'd1, 8'h00, 2'd0);
    step(1'b1, 2'd2, 8'h0B, 2'd2);
    check("R10 same-cycle write forwarded", dacCode, 12'hB00);

    // R11: disabling control write together with overflow
    step(1'b1, 2'd1, 8'h44, 2'd0);
    step(1'b1, 2'd0, 8'h00, 2'd2);
    check("R11 old settings take pulse", dacCode, 12'hB44);
    check("R11 now disabled", {11'd0, dacEnabled}, 12'h000);
    step(1'b1, 2'd1, 8'h77, 2'd0);
    step(1'b0, 2'd0, 8'h00, 2'd2);
    check("R9 R11 later pulse ignored", dacCode, 12'hB44);

    // R6: upper bits of high byte ignored
    step(1'b1, 2'd0, 8'h80, 2'd0);
    step(1'b1, 2'd1, 8'h01, 2'd0);
    step(1'b1, 2'd2, 8'hF2, 2'd0);
    check("R6 high upper nibble dropped", dacCode, 12'h201);

    // R7: low nibble dropped when left-justified
    step(1'b1, 2'd0, 8'h87, 2'd0);
    step(1'b1, 2'd1, 8'h0F, 2'd0);
    step(1'b1, 2'd2, 8'h80, 2'd0);
    check("R7 low nibble dropped", dacCode, 12'h800);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule